// File: doc/BRIEF.md
# I2C Master Bit-Phase Timing Engine

This block is the bit-level engine of an I2C master. It runs one bus operation per command: a START (plain or repeated), a STOP, or a single data bit that is sent or received. It sets open-drain drive enables for SCL and SDA so that every phase lasts a programmed number of ticks of an external clock-enable from a pre-divider. A higher-level controller shifts the bytes and issues one command per bit. That controller also sets two 3-bit timing codes. The low code sets the minimum SCL low time, the bus-free time and the repeated-START setup time. The high code sets the minimum SCL high time, the STOP setup time and the START hold time.

The block samples SCL through a two-stage synchronizer. A slave that holds SCL low therefore stretches the low phase, because the high count waits until SCL is really seen high. A faster master that pulls SCL low during the high phase cuts that phase short, and the block then drives SCL low itself. The timing codes are captured when a command is accepted.

Top module: `i2c_scl_timing_gen`

## Requirements
- R1: With a low code L (0..7) captured at acceptance, every SCL-low counting phase lasts N = L+2 ticks. A data bit accepted with a tick on every clock cycle reports done on the (N+M+4)th clock cycle after acceptance, counting the cycle after the accepting edge as the first.
- R2: With a high code H (0..7), every high-side counting phase lasts M = H+2 ticks. For a data bit with no other bus activity, the block releases SCL for M+3 clock cycles: two synchronizer stages, one cycle to detect SCL high, then M cycles of high count.
- R3: Counters advance only in cycles where `tick` is 1. If `tick` is held low for the first S cycles after a data bit is accepted, done moves S cycles later.
- R4: After releasing SCL, the high count does not start until the synchronized SCL reads 1. If another device holds the line low for X more cycles, SCL stays released for X+M+3 cycles.
- R5: If the synchronized SCL reads 0 during a data bit's high count, the block drives SCL low and reports done on the next edge. If the line is pulled low K cycles after release (1 <= K < M), SCL stays released for K+3 cycles.
- R6: START from an idle bus: SCL and SDA stay released through a bus-free count of N ticks. Then SDA is driven low for a hold of M ticks, then SCL is driven low and done is reported. With a tick every cycle, SDA goes low in cycle N+2 and done comes in cycle N+M+2.
- R7: Repeated START while SCL is driven low: SDA is released and SCL held low for N ticks. SCL is then released, and after SCL is seen high a setup count of N ticks runs, followed by the hold of R6. SDA goes low in cycle 2N+4, done comes in cycle 2N+M+4, and SCL is released for N+M+3 cycles.
- R8: STOP: SDA is driven low while SCL is held low for N ticks. SCL is then released, and after SCL is seen high a setup count of M ticks runs. Then SDA is released and done is reported in cycle N+M+4. Both lines end released.
- R9: `cmd_code` values: 0 START, 1 STOP, 2 WRITE, 3 READ. WRITE drives `sda_drive` = NOT `cmd_wbit` during the bit and keeps it steady while SCL is released. READ releases SDA, and `done_rbit` reports the synchronized SDA value sampled when the synchronized SCL is first seen high.
- R10: `cmd_ready` is 1 only when the block is idle. A command is taken when `cmd_valid` and `cmd_ready` are both 1, and `cmd_ready` drops on the next cycle. `done` is a one-cycle pulse on the edge where the block returns to idle.
- R11: After reset both drive enables are 0 (lines released), `cmd_ready` is 1 and `done` is 0.
- R12: While SCL is released, SDA changes only to form a START (falling) or a STOP (rising on the line). All other SDA changes happen while SCL is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock-enable from the pre-divider; one count per asserted cycle |
| cfg_lo | input | 3 | Low-time code; phase length is code+2 ticks |
| cfg_hi | input | 3 | High-time code; phase length is code+2 ticks |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block is idle and will take a command |
| cmd_code | input | 2 | 0 START, 1 STOP, 2 WRITE bit, 3 READ bit |
| cmd_wbit | input | 1 | Bit value for WRITE |
| done | output | 1 | One-cycle completion pulse |
| done_rbit | output | 1 | Sampled SDA value of the last data bit |
| scl_drive | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |

## Verification
The bench sweeps all 64 combinations of the low and high codes with data bits and compares each phase length against the code+2 arithmetic. An off-by-one in the code offset, or a count that includes or skips the entry cycle, shows up as a shifted done cycle. It holds the tick low for a while after acceptance, which catches a counter that runs on the system clock instead of the tick. It stretches SCL from outside, which catches a design that starts the high count on its own release and not on the observed line. It also cuts the high phase short with an outside pull, which catches a design that ignores other masters and keeps SCL released too long. START, repeated START and STOP are timed from their observed SDA edges, and the bench checks that SDA never moves during the high part of a data bit.

// File: rtl/scl_tg_pkg.sv
`timescale 1ns/1ps
package scl_tg_pkg;

    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_STOP  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_READ  = 2'd3
    } tg_cmd_e;

    typedef enum logic [3:0] {
        TG_IDLE     = 4'd0,
        TG_RS_LOW   = 4'd1,
        TG_ST_RISE  = 4'd2,
        TG_ST_SETUP = 4'd3,
        TG_ST_HOLD  = 4'd4,
        TG_SP_LOW   = 4'd5,
        TG_SP_RISE  = 4'd6,
        TG_SP_SETUP = 4'd7,
        TG_BT_LOW   = 4'd8,
        TG_BT_RISE  = 4'd9,
        TG_BT_HIGH  = 4'd10
    } tg_state_e;

endpackage

// File: rtl/scl_tg_sync.sv
`timescale 1ns/1ps
module scl_tg_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign chain_d[s] = d;
            end else begin : g_next
                assign chain_d[s] = chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/scl_tg_phase_cnt.sv
`timescale 1ns/1ps
module scl_tg_phase_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt_d, cnt_q;

    // Expires on the tick that completes `limit` ticks in the current phase.
    assign expire = tick && (cnt_q == limit - 1'b1);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/i2c_scl_timing_gen.sv
`timescale 1ns/1ps
module i2c_scl_timing_gen
    import scl_tg_pkg::*;
#(
    parameter int FIELD_W     = 3,
    parameter int SYNC_STAGES = 2,
    parameter int RESET_CODE  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [FIELD_W-1:0] cfg_lo,
    input  logic [FIELD_W-1:0] cfg_hi,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_code,
    input  logic               cmd_wbit,
    output logic               done,
    output logic               done_rbit,
    output logic               scl_drive,
    output logic               sda_drive,
    input  logic               scl_in,
    input  logic               sda_in
);
    localparam int CW = $clog2((1 << FIELD_W) + 2) + 1;
    localparam logic [CW-1:0] OFFSET  = CW'(2);
    localparam logic [CW-1:0] RST_TKS = CW'(RESET_CODE) + OFFSET;

    typedef struct packed {
        tg_state_e     state;
        logic          scl_drv;
        logic          sda_drv;
        logic          sda_val;
        logic          done;
        logic          rbit;
        logic [CW-1:0] lo_t;
        logic [CW-1:0] hi_t;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0]    line_s;
    logic          scl_s, sda_s;
    logic          expire, clr;
    logic [CW-1:0] lim;
    tg_state_e     st_q;
    logic [CW-1:0] lo_t_q;

    scl_tg_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b11)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sda_in, scl_in}),
        .q    (line_s)
    );
    assign scl_s = line_s[0];
    assign sda_s = line_s[1];

    scl_tg_phase_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (tick),
        .limit (lim),
        .expire(expire)
    );

    assign clr = (r_d.state != r_q.state);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        lim      = r_q.lo_t;
        case (r_q.state)
            TG_IDLE: begin
                if (cmd_valid) begin
                    r_d.lo_t = CW'(cfg_lo) + OFFSET;
                    r_d.hi_t = CW'(cfg_hi) + OFFSET;
                    case (tg_cmd_e'(cmd_code))
                        CMD_START: begin
                            r_d.state = r_q.scl_drv ? TG_RS_LOW : TG_ST_RISE;
                        end
                        CMD_STOP: begin
                            r_d.scl_drv = 1'b1;
                            r_d.state   = TG_SP_LOW;
                        end
                        CMD_WRITE: begin
                            r_d.scl_drv = 1'b1;
                            r_d.sda_val = ~cmd_wbit;
                            r_d.state   = TG_BT_LOW;
                        end
                        default: begin
                            r_d.scl_drv = 1'b1;
                            r_d.sda_val = 1'b0;
                            r_d.state   = TG_BT_LOW;
                        end
                    endcase
                end
            end
            TG_RS_LOW: begin
                r_d.sda_drv = 1'b0;
                if (expire) begin
                    r_d.scl_drv = 1'b0;
                    r_d.state   = TG_ST_RISE;
                end
            end
            TG_ST_RISE: begin
                if (scl_s) r_d.state = TG_ST_SETUP;
            end
            TG_ST_SETUP: begin
                if (expire) begin
                    r_d.sda_drv = 1'b1;
                    r_d.state   = TG_ST_HOLD;
                end
            end
            TG_ST_HOLD: begin
                lim = r_q.hi_t;
                if (expire) begin
                    r_d.scl_drv = 1'b1;
                    r_d.done    = 1'b1;
                    r_d.state   = TG_IDLE;
                end
            end
            TG_SP_LOW: begin
                r_d.sda_drv = 1'b1;
                if (expire) begin
                    r_d.scl_drv = 1'b0;
                    r_d.state   = TG_SP_RISE;
                end
            end
            TG_SP_RISE: begin
                if (scl_s) r_d.state = TG_SP_SETUP;
            end
            TG_SP_SETUP: begin
                lim = r_q.hi_t;
                if (expire) begin
                    r_d.sda_drv = 1'b0;
                    r_d.done    = 1'b1;
                    r_d.state   = TG_IDLE;
                end
            end
            TG_BT_LOW: begin
                r_d.sda_drv = r_q.sda_val;
                if (expire) begin
                    r_d.scl_drv = 1'b0;
                    r_d.state   = TG_BT_RISE;
                end
            end
            TG_BT_RISE: begin
                if (scl_s) begin
                    r_d.rbit  = sda_s;
                    r_d.state = TG_BT_HIGH;
                end
            end
            TG_BT_HIGH: begin
                lim = r_q.hi_t;
                // Another master pulling SCL low ends the high phase at once.
                if (expire || !scl_s) begin
                    r_d.scl_drv = 1'b1;
                    r_d.done    = 1'b1;
                    r_d.state   = TG_IDLE;
                end
            end
            default: r_d.state = TG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= TG_IDLE;
            r_q.lo_t  <= RST_TKS;
            r_q.hi_t  <= RST_TKS;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = (r_q.state == TG_IDLE);
    assign done      = r_q.done;
    assign done_rbit = r_q.rbit;
    assign scl_drive = r_q.scl_drv;
    assign sda_drive = r_q.sda_drv;
    assign st_q      = r_q.state;
    assign lo_t_q    = r_q.lo_t;
endmodule

// File: rtl/i2c_tg_chk.sv
`timescale 1ns/1ps
module i2c_tg_chk
    import scl_tg_pkg::*;
#(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          done,
    input logic          scl_drive,
    input logic          sda_drive,
    input logic          scl_s,
    input tg_state_e     st_q,
    input logic [CW-1:0] lo_t_q
);
    localparam int RW = CW + 2;
    logic [RW-1:0] lo_run;

    // Ticks seen while SCL has been driven low, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run <= '0;
        end else if (!scl_drive) begin
            lo_run <= '0;
        end else if (tick && (lo_run != {RW{1'b1}})) begin
            lo_run <= lo_run + 1'b1;
        end
    end

    a_r1_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive) |-> (lo_run >= RW'(lo_t_q)));

    a_r4_sync_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive) |=> !scl_drive ##1 !scl_drive);

    a_r5_cut_short: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TG_BT_HIGH && !scl_s) |=> (scl_drive && done));

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    a_r12_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_drive) && !$past(scl_drive)) |-> (st_q == TG_ST_HOLD));

    a_r12_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_drive) && !$past(scl_drive)) |-> done);
endmodule

bind i2c_scl_timing_gen i2c_tg_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .done     (done),
    .scl_drive(scl_drive),
    .sda_drive(sda_drive),
    .scl_s    (scl_s),
    .st_q     (st_q),
    .lo_t_q   (lo_t_q)
);

// File: tb/sim_i2c_scl_timing_gen.sv
`timescale 1ns/1ps
module sim_i2c_scl_timing_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic [2:0] cfg_lo = 3'd7, cfg_hi = 3'd7;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_code = 2'd0;
    logic       cmd_wbit = 1'b0;
    logic       done, done_rbit, scl_drive, sda_drive;
    logic       ext_pull = 1'b0, slave_sda = 1'b0;
    logic       scl_in, sda_in;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign scl_in = !(scl_drive || ext_pull);
    assign sda_in = !(sda_drive || slave_sda);

    i2c_scl_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick_en),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_wbit(cmd_wbit),
        .done(done), .done_rbit(done_rbit),
        .scl_drive(scl_drive), .sda_drive(sda_drive),
        .scl_in(scl_in), .sda_in(sda_in)
    );

    int  t_done, t_sda, rel;
    logic sda_rel, sda_chg, rdy_after;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issues one command and observes it until done, sampling at negedges.
    task automatic run_cmd(input logic [1:0] code, input logic wb,
                           input int stall, input int xs, input int kc);
        bit seen0 = 0;
        int t = 0;
        tick_en  = (stall == 0);
        ext_pull = (xs > 0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_wbit = wb;
        @(posedge clk);
        t_sda = -1; rel = 0; sda_chg = 0; sda_rel = 0; rdy_after = 1;
        forever begin
            @(negedge clk);
            t++;
            if (t == 1) begin
                cmd_valid = 1'b0;
                rdy_after = cmd_ready;
            end
            tick_en = (t > stall);
            if (!sda_drive) seen0 = 1;
            else if (seen0 && t_sda < 0) t_sda = t;
            if (!scl_drive) begin
                rel++;
                if (rel == 1) sda_rel = sda_drive;
                else if (sda_drive != sda_rel && !done) sda_chg = 1;
            end
            ext_pull = (xs > 0 && rel <= xs) || (kc > 0 && rel > kc);
            if (done || t > 2000) break;
        end
        t_done   = t;
        ext_pull = 1'b0;
        tick_en  = 1'b1;
    endtask

    task automatic after_done();
        @(negedge clk);
        chk("R10 done is one cycle", int'(done), 0);
        chk("R10 ready back after done", int'(cmd_ready), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int n, m;
        repeat (3) @(negedge clk);
        chk("R11 scl released in reset", int'(scl_drive), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 scl released", int'(scl_drive), 0);
        chk("R11 sda released", int'(sda_drive), 0);
        chk("R11 ready", int'(cmd_ready), 1);
        chk("R11 no done", int'(done), 0);

        // R6: START from idle bus, codes 7/7 -> N=M=9
        run_cmd(2'd0, 1'b0, 0, 0, 0);
        chk("R6 sda fall cycle", t_sda, 11);
        chk("R6 done cycle", t_done, 20);
        chk("R6 scl driven at done", int'(scl_drive), 1);
        chk("R10 ready low after accept", int'(rdy_after), 0);
        after_done();

        // R1 R2 R9: sweep every code pair with data bits
        for (int lo = 0; lo < 8; lo++) begin
            for (int hi = 0; hi < 8; hi++) begin
                logic wb;
                wb = logic'((lo ^ hi) & 1);
                cfg_lo = 3'(lo); cfg_hi = 3'(hi);
                n = lo + 2; m = hi + 2;
                run_cmd(2'd2, wb, 0, 0, 0);
                chk("R1 bit done cycle", t_done, n + m + 4);
                chk("R2 scl released cycles", rel, m + 3);
                chk("R9 write sda drive", int'(sda_rel), int'(!wb));
                chk("R12 sda steady while scl high", int'(sda_chg), 0);
            end
        end

        cfg_lo = 3'd3; cfg_hi = 3'd5; n = 5; m = 7;
        // R9: reads
        slave_sda = 1'b1;
        run_cmd(2'd3, 1'b0, 0, 0, 0);
        chk("R9 read sda released", int'(sda_rel), 0);
        chk("R9 read bit low", int'(done_rbit), 0);
        slave_sda = 1'b0;
        run_cmd(2'd3, 1'b0, 0, 0, 0);
        chk("R9 read bit high", int'(done_rbit), 1);
        after_done();

        // R3: tick withheld for 6 cycles
        run_cmd(2'd2, 1'b1, 6, 0, 0);
        chk("R3 stalled done cycle", t_done, 6 + n + m + 4);
        chk("R3 release length unchanged", rel, m + 3);

        // R4: stretching by 7 cycles
        run_cmd(2'd2, 1'b0, 0, 7, 0);
        chk("R4 stretched release", rel, 7 + m + 3);
        chk("R4 stretched done cycle", t_done, n + 7 + m + 4);

        // R5: another master cuts the high phase after 2 cycles
        cfg_hi = 3'd7; m = 9;
        run_cmd(2'd2, 1'b1, 0, 0, 2);
        chk("R5 cut release length", rel, 5);
        chk("R5 cut done cycle", t_done, n + 2 + 4);
        chk("R5 scl driven after cut", int'(scl_drive), 1);
        cfg_hi = 3'd5; m = 7;

        // R7: repeated START
        run_cmd(2'd0, 1'b0, 0, 0, 0);
        chk("R7 sda fall cycle", t_sda, 2 * n + 4);
        chk("R7 done cycle", t_done, 2 * n + m + 4);
        chk("R7 scl released cycles", rel, n + m + 3);

        // R8: STOP
        run_cmd(2'd1, 1'b0, 0, 0, 0);
        chk("R8 done cycle", t_done, n + m + 4);
        chk("R8 scl released cycles", rel, m + 4);
        chk("R8 sda released at end", int'(sda_drive), 0);
        chk("R8 scl released at end", int'(scl_drive), 0);
        after_done();

        // R6: START after STOP honours the bus-free count
        cfg_lo = 3'd0; cfg_hi = 3'd1; n = 2; m = 3;
        run_cmd(2'd0, 1'b0, 0, 0, 0);
        chk("R6 bus-free sda fall", t_sda, n + 2);
        chk("R6 short done cycle", t_done, n + m + 2);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule